// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 interrupt inputs and drives a single request line towards a processor. Source number 0 is reserved and never requests. Every other source carries a 2-bit trigger selection (active low, active high, falling edge, rising edge) and a priority from 0 to 7. Each raw input goes through a two-flop synchronizer. Level sources follow the synchronized value. Edge sources set a sticky detector that stays set until software clears it with a single indexed write.

The controller compares every pending source's priority against a programmable threshold and picks one winner. The winner is the source with the highest priority. When several sources share that priority, the lowest source number wins. A status word gives the winner's number, or sets a flag bit when nothing qualifies. A global enable bit must be set before anything is forwarded.

Software works the block through a simple word-addressed register port. Writes take effect at the next clock edge. Reads are combinational on the address.

Top module: `irq_prio_ctrl`

Register words (5-bit word address):

| Address | Contents |
|---|---|
| 0x00 | Control: bit 0 is the global enable. |
| 0x01 | Threshold: bits 2:0. |
| 0x02, 0x03 | Edge-clear ports for sources 0–31 and 32–63. Write-only; they read back as zero. |
| 0x04 | Status. Read-only. |
| 0x08–0x0B | Trigger selections. |
| 0x10–0x1F | Priority slots. |

## Requirements
- R1: After reset the request line is low and the status word reads 0x0001_0000. The control, threshold, trigger and priority words all read zero.
- R2: Within a group of 32, let n be a source's offset. Its priority sits in word 0x10 + 8·group + n[3:1], in byte lane 2·n[4] + n[0]. Only the low 3 bits of each byte are kept; the upper 5 bits read back as zero.
- R3: A source's 2-bit trigger field sits in word 0x08 + 2·group + n[3], at bit position 2·(8·n[4] + n[2:0]). The codes are 0 = active low, 1 = active high, 2 = falling edge, 3 = rising edge. All four codes are stored and read back.
- R4: Level sources are not latched. A change at the raw input reaches the request line after exactly two clock edges, and the request follows the input back when it returns to idle.
- R5: A source in an edge mode sets its detector on the selected transition of its synchronized input. This raises the request three clock edges after the raw change. The detector stays set after the input returns to idle.
- R6: Writing word 0x02 (sources 0–31) or 0x03 (sources 32–63) clears detectors. Bit 8 together with index bits 3:0 clears offset {0, index}. Bit 24 together with index bits 19:16 clears offset {1, index}. Both halves may clear in the same write. A write to the other group's port has no effect. A transition detected on the same edge as a clear leaves the detector set.
- R7: A pending source is forwarded only when its priority is strictly greater than the threshold, so priority 0 never forwards.
- R8: While control bit 0 is clear, the request line is low and the status word shows the no-request flag. Detectors keep their state, and the request returns once the bit is set again.
- R9: The status word holds the winner's number in bits 5:0, with bit 16 clear. If nothing qualifies, it reads 0x0001_0000. The winner has the highest priority, ties go to the lower number, and the request line is high exactly when a winner exists.
- R10: Source 0 never requests, whatever its input, trigger selection or priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Raw interrupt inputs, one per source number |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Request line to the processor |

## Verification
The two functions that can fall on the same clock edge are the setting of an edge detector by a fresh transition and software's clear write for that same source. The bench times a raw rising change so that the detected transition arrives on the exact edge where a clear word targeting that source is sampled, then checks that the source is still the winner. A companion case clears two detectors from the two halves of one write word, and a reference model compares the request line and the status word on every clock throughout.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned GRP_SZ     = 32;
  localparam int unsigned NONE_BIT   = 16;
  localparam int unsigned CLR_EN_BIT = 8;
  localparam int unsigned HALF_SHIFT = 16;

  localparam logic [ADDR_W-1:0] A_CTL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_MASK   = 5'h01;
  localparam logic [ADDR_W-1:0] A_CLR0   = 5'h02;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'h04;
  localparam logic [ADDR_W-1:0] A_MODE0  = 5'h08;
  localparam logic [ADDR_W-1:0] A_PRIO0  = 5'h10;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  // word holding the trigger field of source s
  function automatic logic [ADDR_W-1:0] mode_addr(input int s);
    return A_MODE0 + ADDR_W'((s / GRP_SZ) * 2 + ((s >> 3) & 1));
  endfunction

  // bit position of that field
  function automatic int mode_pos(input int s);
    return ((((s & 16) >> 1) | (s & 7)) * 2);
  endfunction

  // word holding the priority slot of source s
  function automatic logic [ADDR_W-1:0] prio_addr(input int s);
    return A_PRIO0 + ADDR_W'((s / GRP_SZ) * 8 + ((s % 16) / 2));
  endfunction

  // bit position of the byte slot
  function automatic int prio_pos(input int s);
    return ((s & 16) + (s & 1) * 8);
  endfunction

  function automatic logic [ADDR_W-1:0] clr_addr(input int s);
    return A_CLR0 + ADDR_W'(s / GRP_SZ);
  endfunction

  // does a clear word name source s (within its group)?
  function automatic logic clr_match(input logic [WORD_W-1:0] w, input int s);
    logic [3:0] idx;
    idx = 4'(s % 16);
    if ((s & 16) != 0)
      return w[CLR_EN_BIT + HALF_SHIFT] && (w[HALF_SHIFT +: 4] == idx);
    return w[CLR_EN_BIT] && (w[3:0] == idx);
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic found, input logic [7:0] id);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[NONE_BIT] = ~found;
    w[7:0]      = found ? id : 8'h00;
    return w;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  raw_i,
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  pend_o,
  output logic  latch_o,
  output logic  hit_o
);

  // chain_q[0] is the newest sample; one extra stage keeps the previous synced value
  logic [SYNC_STAGES:0] chain_q;
  logic synced, prev, rise, fall, latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], raw_i};
  end

  assign synced = chain_q[SYNC_STAGES-1];
  assign prev   = chain_q[SYNC_STAGES];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;

  always_comb begin
    unique case (mode_i)
      TRIG_FALL: hit_o = fall;
      TRIG_RISE: hit_o = rise;
      default:   hit_o = 1'b0;
    endcase
  end

  // a fresh transition outranks a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= 1'b0;
    else if (hit_o) latch_q <= 1'b1;
    else if (clr_i) latch_q <= 1'b0;
  end

  always_comb begin
    unique case (mode_i)
      TRIG_LOW:  pend_o = ~synced;
      TRIG_HIGH: pend_o = synced;
      default:   pend_o = latch_q;
    endcase
  end

  assign latch_o = latch_q;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [WORD_W-1:0]         wdata_i,
  input  logic [WORD_W-1:0]         status_i,
  output logic [WORD_W-1:0]         rdata_o,
  output logic                      en_o,
  output logic [PRIO_W-1:0]         mask_o,
  output logic [2*NUM_SRC-1:0]      mode_o,
  output logic [PRIO_W*NUM_SRC-1:0] prio_o,
  output logic [NUM_SRC-1:0]        clr_o
);

  logic              en_q;
  logic [PRIO_W-1:0] mask_q;
  logic [1:0]        mode_q [NUM_SRC];
  logic [PRIO_W-1:0] prio_q [NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        mode_q[s] <= '0;
        prio_q[s] <= '0;
      end
    end else if (we_i) begin
      if (addr_i == A_CTL)  en_q   <= wdata_i[0];
      if (addr_i == A_MASK) mask_q <= wdata_i[PRIO_W-1:0];
      for (int s = 0; s < NUM_SRC; s++) begin
        if (addr_i == mode_addr(s)) mode_q[s] <= wdata_i[mode_pos(s) +: 2];
        if (addr_i == prio_addr(s)) prio_q[s] <= wdata_i[prio_pos(s) +: PRIO_W];
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign mode_o[2*s +: 2]           = mode_q[s];
    assign prio_o[PRIO_W*s +: PRIO_W] = prio_q[s];
    assign clr_o[s] = we_i && (addr_i == clr_addr(s)) && clr_match(wdata_i, s);
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTL:    rdata_o[0]          = en_q;
      A_MASK:   rdata_o[PRIO_W-1:0] = mask_q;
      A_STATUS: rdata_o             = status_i;
      default:  ;
    endcase
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr_i == mode_addr(s)) rdata_o[mode_pos(s) +: 2]      = mode_q[s];
      if (addr_i == prio_addr(s)) rdata_o[prio_pos(s) +: PRIO_W] = prio_q[s];
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 6
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_i,
  input  logic                      en_i,
  input  logic [PRIO_W-1:0]         mask_i,
  output logic                      found_o,
  output logic [ID_W-1:0]           win_id_o,
  output logic [PRIO_W-1:0]         win_prio_o
);

  localparam int RESERVED_SRC = 0;

  logic [PRIO_W-1:0] cur;
  logic              elig;

  // scan from the top down; ">=" lets a lower number take over an equal level
  always_comb begin
    found_o    = 1'b0;
    win_id_o   = '0;
    win_prio_o = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      cur  = prio_i[PRIO_W*s +: PRIO_W];
      elig = (s != RESERVED_SRC) && en_i && pend_i[s] && (cur > mask_i);
      if (elig && (cur >= win_prio_o)) begin
        found_o    = 1'b1;
        win_id_o   = ID_W'(s);
        win_prio_o = cur;
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we_i,
  input  logic [4:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);

  localparam int unsigned ID_W = $clog2(NUM_SRC);

  logic                      en_w;
  logic [PRIO_W-1:0]         mask_w;
  logic [2*NUM_SRC-1:0]      mode_w;
  logic [PRIO_W*NUM_SRC-1:0] prio_w;
  logic [NUM_SRC-1:0]        clr_vec;
  logic [NUM_SRC-1:0]        pend_vec;
  logic [NUM_SRC-1:0]        edge_latch;
  logic [NUM_SRC-1:0]        edge_hit;
  logic                      found_w;
  logic [ID_W-1:0]           win_id_w;
  logic [PRIO_W-1:0]         win_prio_w;
  logic [WORD_W-1:0]         status_w;

  irq_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .status_i (status_w),
    .rdata_o  (bus_rdata_o),
    .en_o     (en_w),
    .mask_o   (mask_w),
    .mode_o   (mode_w),
    .prio_o   (prio_w),
    .clr_o    (clr_vec)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cell
    irq_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (src_i[s]),
      .mode_i  (trig_e'(mode_w[2*s +: 2])),
      .clr_i   (clr_vec[s]),
      .pend_o  (pend_vec[s]),
      .latch_o (edge_latch[s]),
      .hit_o   (edge_hit[s])
    );
  end

  irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .pend_i     (pend_vec),
    .prio_i     (prio_w),
    .en_i       (en_w),
    .mask_i     (mask_w),
    .found_o    (found_w),
    .win_id_o   (win_id_w),
    .win_prio_o (win_prio_w)
  );

  assign status_w = status_word(found_w, 8'(win_id_w));
  assign irq_o    = found_w;

endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic [ID_W-1:0]    win_id,
  input logic               en,
  input logic [PRIO_W-1:0]  mask,
  input logic [PRIO_W-1:0]  win_prio,
  input logic [NUM_SRC-1:0] latch,
  input logic [NUM_SRC-1:0] hit,
  input logic [NUM_SRC-1:0] clr
);

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  p_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win_prio > mask));

  p_src0_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win_id != '0));

  p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(latch & ~clr) & ~latch) == '0));

  p_clear_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr & ~hit) & latch) == '0));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit) & ~latch) == '0));

endmodule

bind irq_prio_ctrl irq_ctl_checker #(
  .NUM_SRC (NUM_SRC),
  .PRIO_W  (PRIO_W),
  .ID_W    (ID_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq_o),
  .win_id   (win_id_w),
  .en       (en_w),
  .mask     (mask_w),
  .win_prio (win_prio_w),
  .latch    (edge_latch),
  .hit      (edge_hit),
  .clr      (clr_vec)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src;
  logic        we;
  logic [4:0]  addr;
  logic [31:0] wdata;
  wire  [31:0] rdata;
  wire         irq;

  always #10 clk = ~clk;  // 50 MHz

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_mode [NSRC];
  int          m_prio [NSRC];
  bit          m_en;
  int          m_mask;
  bit   [63:0] m_lat;
  logic [63:0] h0, h1, h2;  // raw input as sampled on the last three edges

  function automatic int tb_mode_reg(input int s);
    return 8 + 2 * (s / 32) + ((s % 16) >= 8 ? 1 : 0);
  endfunction
  function automatic int tb_mode_sh(input int s);
    int n = s % 32;
    return 2 * ((n >= 16 ? 8 : 0) + (n % 8));
  endfunction
  function automatic int tb_prio_reg(input int s);
    return 16 + 8 * (s / 32) + ((s % 16) >> 1);
  endfunction
  function automatic int tb_prio_sh(input int s);
    int n = s % 32;
    return 8 * ((n >= 16 ? 2 : 0) + (n % 2));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) begin m_mode[s] = 0; m_prio[s] = 0; end
      m_en = 0; m_mask = 0; m_lat = '0;
      h0 = '1; h1 = '1; h2 = '1;
    end else begin
      for (int s = 0; s < NSRC; s++) begin
        bit hit, clr;
        hit = (m_mode[s] == 3 && h1[s] && !h2[s]) || (m_mode[s] == 2 && !h1[s] && h2[s]);
        clr = 0;
        if (we && int'(addr) == 2 + s / 32) begin
          if ((s % 32) < 16) clr = wdata[8]  && (int'(wdata[3:0])   == s % 16);
          else               clr = wdata[24] && (int'(wdata[19:16]) == s % 16);
        end
        if (hit) m_lat[s] = 1;
        else if (clr) m_lat[s] = 0;
      end
      if (we) begin
        if (addr == 5'd0) m_en = wdata[0];
        if (addr == 5'd1) m_mask = int'(wdata[2:0]);
        for (int s = 0; s < NSRC; s++) begin
          if (int'(addr) == tb_mode_reg(s)) m_mode[s] = int'((wdata >> tb_mode_sh(s)) & 32'h3);
          if (int'(addr) == tb_prio_reg(s)) m_prio[s] = int'((wdata >> tb_prio_sh(s)) & 32'h7);
        end
      end
      h2 = h1; h1 = h0; h0 = src;
    end
  end

  function automatic logic [31:0] model_status();
    int best = -1;
    int bp = 0;
    for (int s = 1; s < NSRC; s++) begin
      bit p;
      p = (m_mode[s] >= 2) ? m_lat[s] : ((m_mode[s] == 1) ? h1[s] : !h1[s]);
      if (m_en && p && m_prio[s] > m_mask && m_prio[s] > bp) begin
        best = s; bp = m_prio[s];
      end
    end
    return (best < 0) ? 32'h0001_0000 : 32'(best);
  endfunction

  // R9: per-clock comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [31:0] es;
      es = model_status();
      chk("R9 model irq", {31'b0, irq}, {31'b0, ~es[16]});
      if (!we && addr == 5'd4) chk("R9 model status", rdata, es);
    end
  end

  // ---------------- bus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 5'd4; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata; addr = 5'd4;
  endtask

  task automatic set_prio(input int s, input int p);
    logic [31:0] w;
    int sh = tb_prio_sh(s);
    rd(5'(tb_prio_reg(s)), w);
    w = (w & ~(32'hFF << sh)) | (32'(p) << sh);
    wr(5'(tb_prio_reg(s)), w);
  endtask

  task automatic set_mode(input int s, input int m);
    logic [31:0] w;
    int sh = tb_mode_sh(s);
    rd(5'(tb_mode_reg(s)), w);
    w = (w & ~(32'h3 << sh)) | (32'(m) << sh);
    wr(5'(tb_mode_reg(s)), w);
  endtask

  task automatic drive(input int s, input logic v);
    @(negedge clk); src[s] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic irq_after_edge(input string tag, input logic exp);
    @(posedge clk); #5;
    chk(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] d;
    src = '1; we = 1'b0; addr = 5'd4; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(5'h04, d); chk("R1 status after reset", d, 32'h0001_0000);
    rd(5'h00, d); chk("R1 control after reset", d, 32'h0);
    rd(5'h01, d); chk("R1 threshold after reset", d, 32'h0);
    rd(5'h10, d); chk("R1 priority word after reset", d, 32'h0);
    rd(5'h0B, d); chk("R1 trigger word after reset", d, 32'h0);

    // R2: slot layout, only 3 bits kept per byte
    wr(5'h13, 32'hFFFF_FFFF);
    rd(5'h13, d); chk("R2 byte slots keep 3 bits", d, 32'h0707_0707);
    wr(5'h13, 32'h0);
    set_prio(37, 5);
    rd(5'h1A, d); chk("R2 source 37 slot", d, 32'h0000_0500);
    set_prio(37, 0);

    // R3: trigger fields
    wr(5'h09, 32'hE4E4_E4E4);
    rd(5'h09, d); chk("R3 all codes stored", d, 32'hE4E4_E4E4);
    wr(5'h09, 32'h0);
    set_mode(21, 3);
    rd(5'h08, d); chk("R3 source 21 field", d, 32'h0C00_0000);
    set_mode(21, 0);

    // R4: level, two-edge latency
    drive(5, 1'b0); idle(4);
    wr(5'h01, 32'h1);
    wr(5'h00, 32'h1);
    rd(5'h00, d); chk("R8 control readback", d, 32'h1);
    set_mode(5, 1); set_prio(5, 4);
    idle(1);
    chk("R4 high-level idle", {31'b0, irq}, 32'h0);
    @(negedge clk); src[5] = 1'b1;
    irq_after_edge("R4 one edge after raise", 1'b0);
    irq_after_edge("R4 two edges after raise", 1'b1);
    rd(5'h04, d); chk("R4 winner id", d, 32'd5);
    @(negedge clk); src[5] = 1'b0;
    irq_after_edge("R4 one edge after drop", 1'b1);
    irq_after_edge("R4 two edges after drop", 1'b0);
    set_mode(5, 0);
    rd(5'h04, d); chk("R4 active-low pending", d, 32'd5);
    drive(5, 1'b1); idle(3);
    chk("R4 active-low released", {31'b0, irq}, 32'h0);
    set_prio(5, 0);

    // R5: rising edge on source 40, three-edge latency, sticky
    drive(40, 1'b0); idle(4);
    set_mode(40, 3); set_prio(40, 6);
    @(negedge clk); src[40] = 1'b1;
    irq_after_edge("R5 edge +1", 1'b0);
    irq_after_edge("R5 edge +2", 1'b0);
    irq_after_edge("R5 edge +3", 1'b1);
    drive(40, 1'b0); idle(5);
    rd(5'h04, d); chk("R5 latch held after idle", d, 32'd40);

    // R9: tie goes to lower number, higher level wins
    drive(12, 1'b0); idle(3);
    set_mode(12, 1); set_prio(12, 6);
    drive(12, 1'b1); idle(3);
    rd(5'h04, d); chk("R9 tie lowest number", d, 32'd12);
    set_mode(50, 1); set_prio(50, 7); idle(3);
    rd(5'h04, d); chk("R9 higher level wins", d, 32'd50);
    set_prio(50, 0);
    rd(5'h04, d); chk("R7 priority zero drops", d, 32'd12);

    // R7: strict threshold
    wr(5'h01, 32'h6);
    rd(5'h04, d); chk("R7 equal to threshold", d, 32'h0001_0000);
    set_prio(50, 7);
    rd(5'h04, d); chk("R7 above threshold", d, 32'd50);
    wr(5'h01, 32'h1);
    set_prio(50, 0);
    drive(12, 1'b0); idle(3);
    rd(5'h04, d); chk("R5 latch still pending", d, 32'd40);

    // R6: clear through group-1 port, lower half
    wr(5'h03, 32'h0000_0108);
    chk("R6 clear irq", {31'b0, irq}, 32'h0);
    rd(5'h04, d); chk("R6 cleared", d, 32'h0001_0000);

    // R6: both halves in one write (33 and 49, falling)
    set_mode(33, 2); set_mode(49, 2); set_prio(33, 3); set_prio(49, 3);
    drive(33, 1'b0); drive(49, 1'b0); idle(4);
    rd(5'h04, d); chk("R6 two latched", d, 32'd33);
    wr(5'h03, 32'h0101_0101);
    rd(5'h04, d); chk("R6 both halves cleared", d, 32'h0001_0000);

    // R6: other group's port has no effect
    drive(33, 1'b1); idle(3); drive(33, 1'b0); idle(4);
    wr(5'h02, 32'h0000_0101);
    rd(5'h04, d); chk("R6 wrong group ignored", d, 32'd33);
    wr(5'h03, 32'h0000_0101);

    // R6: transition on the clear edge keeps the detector set
    @(negedge clk); src[40] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 5'h03; wdata = 32'h0000_0108;
    @(negedge clk); we = 1'b0; addr = 5'd4; wdata = '0;
    rd(5'h04, d); chk("R6 set beats clear", d, 32'd40);
    wr(5'h03, 32'h0000_0108);
    rd(5'h04, d); chk("R6 later clear", d, 32'h0001_0000);

    // R10: source 0 never requests
    set_mode(0, 1); set_prio(0, 7); idle(3);
    chk("R10 source 0 quiet", {31'b0, irq}, 32'h0);
    rd(5'h04, d); chk("R10 status none", d, 32'h0001_0000);

    // R8: global enable
    drive(40, 1'b0); idle(2); drive(40, 1'b1); idle(4);
    rd(5'h04, d); chk("R8 latched before disable", d, 32'd40);
    wr(5'h00, 32'h0);
    chk("R8 disabled irq", {31'b0, irq}, 32'h0);
    rd(5'h04, d); chk("R8 disabled status", d, 32'h0001_0000);
    wr(5'h00, 32'h1);
    rd(5'h04, d); chk("R8 re-enabled keeps latch", d, 32'd40);

    idle(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 got=running exp=finished");
      summary();
      $finish;
    end
  end

endmodule